// File: doc/BRIEF.md
# Negated Fused Multiply-Add Result Finalizer

This block is the last stage behind a fused multiply-add datapath that has already multiplied, added, normalised and rounded under the current rounding mode. It takes that rounded, not yet negated result and produces the value written back to the target register. For ordinary values this is a sign inversion. NaN results follow their own sign rules instead. Single-precision results are widened into the 64-bit register format.

The block also maintains the floating-point status register. It updates the sticky exception bits, the summary bits and the five-bit result-class field. When the record bit of the instruction is set, it presents the four summary bits for condition-register field 1 together with a write strobe. The result path and the condition-field path are combinational. The status register is updated on the clock edge at which an accepted operation is strobed.

Top module: `fnm_finalize`

## Requirements
- R1: An operation is accepted only when `valid_i` is 1, `instr_i[31:26]` is 63 (double) or 59 (single), and `instr_i[5:1]` is 31. Otherwise `result_we_o` and `cr1_we_o` stay 0 and the stored status bits `fpscr_o[31:8]` do not change.
- R2: For a double operation with `nan_kind_i` = 0 (not a NaN), `result_o` equals `rnd_res_i` with bit 63 inverted.
- R3: For a single operation, the 32-bit result in `rnd_res_i[31:0]` is first widened exactly to 64-bit format and then negated. Denormal singles become normalised doubles, and infinities and NaNs keep their fraction, shifted left by 29.
- R4: `nan_kind_i` = 1 (quiet NaN propagated from an input) and `nan_kind_i` = 3 (signalling NaN quieted by a disabled invalid exception) both pass the sign bit through unchanged.
- R5: `nan_kind_i` = 2 (default NaN created by a disabled invalid exception) forces the result sign to 0.
- R6: The class field `fpscr_o[16:12]` takes the class of the final result, judged in its source precision. The codes are: NaN 10001, -inf 01001, -normal 01000, -denormal 11000, -zero 10010, +zero 00010, +denormal 10100, +normal 00100, +inf 00101.
- R7: When an invalid indication (`vxsnan_i`, `vxisi_i`, `vximz_i`) coincides with the invalid enable `ctrl_i[7]` = 1, `result_we_o` is 0 and the class field keeps its value.
- R8: OX (bit 28), UX (27), XX (25), VXSNAN (24), VXISI (23) and VXIMZ (20) are ORed in and never cleared. FR (18) and FI (17) are overwritten by every accepted operation.
- R9: FX (bit 31) is set when any exception bit goes from 0 to 1, and it is never cleared. VX (29) is the OR of the invalid sub-bits. FEX (30) is the OR of VX&VE, OX&OE (`ctrl_i[6]`), UX&UE (`ctrl_i[5]`), ZX&ZE (`ctrl_i[4]`) and XX&XE (`ctrl_i[3]`).
- R10: When the record bit `instr_i[0]` is 1, `cr1_we_o` is 1 and `cr1_o` carries {FX,FEX,VX,OX} of the updated status. When the record bit is 0, `cr1_we_o` is 0.
- R11: `fpscr_o[7:0]` mirrors `ctrl_i`. For the operands of the reference example (rounded sum 0xC070D7FFFFFFF6CB with XX, FR and FI raised, from a cleared register), the result is 0x4070D7FFFFFFF6CB, the status reads 0x82064000, and `cr1_o` is 4'b1000.
- R12: After reset, `fpscr_o[31:8]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| instr_i | input | 32 | Instruction word (primary opcode, extended opcode, record bit) |
| rnd_res_i | input | 64 | Rounded result before negation (single in bits 31:0) |
| nan_kind_i | input | 2 | 0 not NaN, 1 propagated quiet NaN, 2 default NaN, 3 quieted signalling NaN |
| ox_i | input | 1 | Overflow raised |
| ux_i | input | 1 | Underflow raised |
| xx_i | input | 1 | Inexact raised |
| fr_i | input | 1 | Fraction rounded up |
| fi_i | input | 1 | Fraction inexact |
| vxsnan_i | input | 1 | Invalid: signalling NaN operand |
| vxisi_i | input | 1 | Invalid: infinity minus infinity |
| vximz_i | input | 1 | Invalid: infinity times zero |
| ctrl_i | input | 8 | Enables VE,OE,UE,ZE,XE (bits 7..3), NI, rounding mode |
| result_o | output | 64 | Final negated result |
| result_we_o | output | 1 | Target register write enable |
| fpscr_o | output | 32 | Status register |
| cr1_o | output | 4 | Condition field 1 value {FX,FEX,VX,OX} |
| cr1_we_o | output | 1 | Condition field 1 write enable |

## Verification
`result_o`, `result_we_o`, `cr1_o` and `cr1_we_o` are combinational, so they are valid in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs just afterwards, before the next rising edge. The status register changes on the rising edge that takes the strobe. The bench reads `fpscr_o` on the following falling edge, one edge after the stimulus. For ignored strobes it reads the register at that same point and compares it with the value it held before.

// File: rtl/fnm_pkg.sv
package fnm_pkg;

    localparam int DW = 64;
    localparam int SW = 32;

    typedef enum logic [1:0] {
        NK_NONE    = 2'd0,
        NK_PROP    = 2'd1,
        NK_DEFAULT = 2'd2,
        NK_QUIET   = 2'd3
    } nan_kind_e;

    localparam logic [5:0] OPC_DBL = 6'd63;
    localparam logic [5:0] OPC_SGL = 6'd59;
    localparam logic [4:0] XO_NMA  = 5'd31;

    // status bit positions (LSB numbering)
    localparam int B_FX = 31, B_FEX = 30, B_VX = 29, B_OX = 28, B_UX = 27;
    localparam int B_ZX = 26, B_XX = 25, B_VXSNAN = 24, B_VXISI = 23;
    localparam int B_VXIMZ = 20, B_FR = 18, B_FI = 17;
    localparam int B_CLS_HI = 16, B_CLS_LO = 12;
    localparam int B_VE = 7, B_OE = 6, B_UE = 5, B_ZE = 4, B_XE = 3;
    localparam int ST_LO = 8;

    localparam logic [31:0] EXC_MASK = 32'h1FF8_0700;
    localparam logic [31:0] VX_MASK  = 32'h01F8_0700;

    function automatic logic [4:0] class_code(input logic s, input logic e_max,
                                              input logic e_zero, input logic f_zero);
        if (e_max)       return f_zero ? (s ? 5'b01001 : 5'b00101) : 5'b10001;
        else if (e_zero) return f_zero ? (s ? 5'b10010 : 5'b00010)
                                       : (s ? 5'b11000 : 5'b10100);
        else             return s ? 5'b01000 : 5'b00100;
    endfunction

    function automatic logic [DW-1:0] widen_sp(input logic [SW-1:0] v);
        logic [7:0]  e;
        logic [22:0] f;
        logic [51:0] tmp;
        int          p;
        e = v[30:23];
        f = v[22:0];
        p = 0;
        if (e == 8'd0 && f == 23'd0) return {v[31], 63'd0};
        if (e == 8'hFF)              return {v[31], 11'h7FF, f, 29'd0};
        if (e != 8'd0)               return {v[31], {3'd0, e} + 11'd896, f, 29'd0};
        for (int i = 0; i < 23; i++) if (f[i]) p = i;
        tmp = {29'd0, f};
        tmp = tmp << (52 - p);
        return {v[31], 11'(874 + p), tmp};
    endfunction

endpackage

// File: rtl/fnm_result_fix.sv
module fnm_result_fix
    import fnm_pkg::*;
(
    input  logic          sgl_i,
    input  nan_kind_e     kind_i,
    input  logic [DW-1:0] res_i,
    output logic [DW-1:0] res_o,
    output logic [4:0]    cls_o
);
    logic [DW-1:0] wide;
    logic          sgn;
    logic          e_max, e_zero, f_zero;

    always_comb begin
        wide = sgl_i ? widen_sp(res_i[SW-1:0]) : res_i;
        unique case (kind_i)
            NK_NONE:    sgn = ~wide[DW-1];
            NK_DEFAULT: sgn = 1'b0;
            default:    sgn = wide[DW-1];
        endcase
        res_o = {sgn, wide[DW-2:0]};
    end

    // class judged in the source precision
    always_comb begin
        if (sgl_i) begin
            e_max  = &res_i[30:23];
            e_zero = ~|res_i[30:23];
            f_zero = ~|res_i[22:0];
        end else begin
            e_max  = &res_i[62:52];
            e_zero = ~|res_i[62:52];
            f_zero = ~|res_i[51:0];
        end
        cls_o = class_code(sgn, e_max, e_zero, f_zero);
    end
endmodule

// File: rtl/fnm_status_reg.sv
module fnm_status_reg
    import fnm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_i,
    input  logic        trap_i,
    input  logic [4:0]  cls_i,
    input  logic        ox_i,
    input  logic        ux_i,
    input  logic        xx_i,
    input  logic        fr_i,
    input  logic        fi_i,
    input  logic        vxsnan_i,
    input  logic        vxisi_i,
    input  logic        vximz_i,
    input  logic [7:0]  ctrl_i,
    output logic [31:0] cur_o,
    output logic [31:0] nxt_o
);
    logic [31:ST_LO] st_q;
    logic [31:0]     old_w, nxt;

    assign old_w = {st_q, ctrl_i};

    always_comb begin
        nxt = old_w;
        if (upd_i) begin
            nxt[B_OX]     = old_w[B_OX]     | ox_i;
            nxt[B_UX]     = old_w[B_UX]     | ux_i;
            nxt[B_XX]     = old_w[B_XX]     | xx_i;
            nxt[B_VXSNAN] = old_w[B_VXSNAN] | vxsnan_i;
            nxt[B_VXISI]  = old_w[B_VXISI]  | vxisi_i;
            nxt[B_VXIMZ]  = old_w[B_VXIMZ]  | vximz_i;
            nxt[B_FR]     = fr_i;
            nxt[B_FI]     = fi_i;
            if (!trap_i) nxt[B_CLS_HI:B_CLS_LO] = cls_i;
            nxt[B_VX]  = |(nxt & VX_MASK);
            nxt[B_FEX] = (nxt[B_VX] & ctrl_i[B_VE]) | (nxt[B_OX] & ctrl_i[B_OE])
                       | (nxt[B_UX] & ctrl_i[B_UE]) | (nxt[B_ZX] & ctrl_i[B_ZE])
                       | (nxt[B_XX] & ctrl_i[B_XE]);
            nxt[B_FX]  = old_w[B_FX] | (|(nxt & ~old_w & EXC_MASK));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= nxt[31:ST_LO];
    end

    assign cur_o = old_w;
    assign nxt_o = nxt;

    a_r8_ox_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(st_q[B_OX]));
    a_r8_vximz_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(st_q[B_VXIMZ]));
    a_r9_fx_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(st_q[B_FX]));
    a_r7_class_hold: assert property (@(posedge clk) disable iff (rst)
        (upd_i && trap_i) |=> $stable(st_q[B_CLS_HI:B_CLS_LO]));
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(st_q));
endmodule

// File: rtl/fnm_finalize.sv
module fnm_finalize
    import fnm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [63:0] rnd_res_i,
    input  logic [1:0]  nan_kind_i,
    input  logic        ox_i,
    input  logic        ux_i,
    input  logic        xx_i,
    input  logic        fr_i,
    input  logic        fi_i,
    input  logic        vxsnan_i,
    input  logic        vxisi_i,
    input  logic        vximz_i,
    input  logic [7:0]  ctrl_i,
    output logic [63:0] result_o,
    output logic        result_we_o,
    output logic [31:0] fpscr_o,
    output logic [3:0]  cr1_o,
    output logic        cr1_we_o
);
    logic       is_dbl, is_sgl, accept, rc, inv_any, trap;
    logic [4:0] cls;
    logic [31:0] nxt;
    logic       unused_fields;

    assign is_dbl  = instr_i[31:26] == OPC_DBL;
    assign is_sgl  = instr_i[31:26] == OPC_SGL;
    assign accept  = valid_i && (is_dbl || is_sgl) && (instr_i[5:1] == XO_NMA);
    assign rc      = instr_i[0];
    assign inv_any = vxsnan_i | vxisi_i | vximz_i;
    assign trap    = inv_any & ctrl_i[B_VE];
    assign unused_fields = ^instr_i[25:6];

    fnm_result_fix u_fix (
        .sgl_i  (is_sgl),
        .kind_i (nan_kind_e'(nan_kind_i)),
        .res_i  (rnd_res_i),
        .res_o  (result_o),
        .cls_o  (cls)
    );

    fnm_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (accept),
        .trap_i   (trap),
        .cls_i    (cls),
        .ox_i     (ox_i),
        .ux_i     (ux_i),
        .xx_i     (xx_i),
        .fr_i     (fr_i),
        .fi_i     (fi_i),
        .vxsnan_i (vxsnan_i),
        .vxisi_i  (vxisi_i),
        .vximz_i  (vximz_i),
        .ctrl_i   (ctrl_i),
        .cur_o    (fpscr_o),
        .nxt_o    (nxt)
    );

    assign result_we_o = accept & ~trap;
    assign cr1_we_o    = accept & rc;
    assign cr1_o       = nxt[31:28];

    a_r10_cr_gate: assert property (@(posedge clk) disable iff (rst)
        !instr_i[0] |-> !cr1_we_o);
    a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
        (inv_any && ctrl_i[B_VE]) |-> !result_we_o);
    a_r5_default_pos: assert property (@(posedge clk) disable iff (rst)
        (valid_i && nan_kind_i == 2'd2) |-> !result_o[63]);
    a_r1_no_accept: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (!result_we_o && !cr1_we_o));
endmodule

// File: tb/fnm_finalize_tb.sv
module fnm_finalize_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] instr_i;
    logic [63:0] rnd_res_i;
    logic [1:0]  nan_kind_i;
    logic        ox_i, ux_i, xx_i, fr_i, fi_i, vxsnan_i, vxisi_i, vximz_i;
    logic [7:0]  ctrl_i;
    logic [63:0] result_o;
    logic        result_we_o;
    logic [31:0] fpscr_o;
    logic [3:0]  cr1_o;
    logic        cr1_we_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fnm_finalize u_dut (.*);

    // {single, kind, rounded input, expected result, expected class}
    localparam int NV = 14;
    localparam logic [135:0] VEC [NV] = '{
        {1'b0, 2'd0, 64'hC070D7FFFFFFF6CB, 64'h4070D7FFFFFFF6CB, 5'b00100},
        {1'b0, 2'd1, 64'hFFF8000000000000, 64'hFFF8000000000000, 5'b10001},
        {1'b0, 2'd2, 64'hFFF8000000000000, 64'h7FF8000000000000, 5'b10001},
        {1'b0, 2'd3, 64'hFFF8000000000001, 64'hFFF8000000000001, 5'b10001},
        {1'b1, 2'd0, 64'h000000003F800000, 64'hBFF0000000000000, 5'b01000},
        {1'b1, 2'd0, 64'h0000000000000001, 64'hB6A0000000000000, 5'b11000},
        {1'b1, 2'd0, 64'h0000000000400000, 64'hB800000000000000, 5'b11000},
        {1'b0, 2'd0, 64'h0000000000000000, 64'h8000000000000000, 5'b10010},
        {1'b0, 2'd0, 64'h7FF0000000000000, 64'hFFF0000000000000, 5'b01001},
        {1'b0, 2'd0, 64'h0000000000000001, 64'h8000000000000001, 5'b11000},
        {1'b0, 2'd0, 64'h8000000000000000, 64'h0000000000000000, 5'b00010},
        {1'b1, 2'd0, 64'h00000000FF800000, 64'h7FF0000000000000, 5'b00101},
        {1'b1, 2'd2, 64'h00000000FFC00000, 64'h7FF8000000000000, 5'b10001},
        {1'b0, 2'd0, 64'h8000000000000001, 64'h0000000000000001, 5'b10100}
    };

    function automatic logic [31:0] mk(input logic sgl, input logic [4:0] xo, input logic r);
        return {sgl ? 6'd59 : 6'd63, 5'd6, 5'd4, 5'd7, 5'd5, xo, r};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        valid_i = 0; instr_i = mk(0, 5'd31, 0); rnd_res_i = '0; nan_kind_i = 0;
        ox_i = 0; ux_i = 0; xx_i = 0; fr_i = 0; fi_i = 0;
        vxsnan_i = 0; vxisi_i = 0; vximz_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; idle();
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        rst = 1; ctrl_i = 8'h00; idle();
        do_reset();
        #1 check("R12 reset status", {32'd0, fpscr_o}, 64'h0);

        // R11 R2 R10: reference example with record bit
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd31, 1); rnd_res_i = 64'hC070D7FFFFFFF6CB;
        xx_i = 1; fr_i = 1; fi_i = 1;
        #1 check("R11 example result", result_o, 64'h4070D7FFFFFFF6CB);
        check("R10 cr1 value", {60'd0, cr1_o}, 64'h8);
        check("R10 cr1 write", {63'd0, cr1_we_o}, 64'd1);
        @(negedge clk); idle();
        #1 check("R11 example status", {32'd0, fpscr_o}, 64'h82064000);

        // R8 R9: sticky bits, FR/FI overwrite, FEX from OX&OE
        ctrl_i = 8'h40;
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd31, 1); rnd_res_i = 64'h3FF0000000000000; ox_i = 1;
        #1 check("R9 cr1 after overflow", {60'd0, cr1_o}, 64'hD);
        @(negedge clk); idle();
        #1 check("R8 R9 status after overflow", {32'd0, fpscr_o}, 64'hD2008040);

        // R10: record bit clear
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd31, 0); rnd_res_i = 64'h3FF0000000000000;
        #1 check("R10 no cr1 write", {63'd0, cr1_we_o}, 64'd0);
        @(negedge clk); idle();

        // R6 R2 R3 R4 R5: table of result and class vectors
        ctrl_i = 8'h00;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            valid_i = 1; instr_i = mk(VEC[i][135], 5'd31, 0);
            nan_kind_i = VEC[i][134:133]; rnd_res_i = VEC[i][132:69];
            #1 check($sformatf("R2 R3 R4 R5 result vec %0d", i), result_o, VEC[i][68:5]);
            check($sformatf("R1 write enable vec %0d", i), {63'd0, result_we_o}, 64'd1);
            @(negedge clk); idle();
            #1 check($sformatf("R6 class vec %0d", i), {59'd0, fpscr_o[16:12]}, {59'd0, VEC[i][4:0]});
        end

        // R7: invalid with enable set
        do_reset();
        ctrl_i = 8'h80;
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd31, 0); rnd_res_i = 64'hC070D7FFFFFFF6CB;
        @(negedge clk); idle();
        #1 check("R6 class before trap", {32'd0, fpscr_o}, 64'h00004080);
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd31, 0); rnd_res_i = 64'h0000000000000000; vximz_i = 1;
        #1 check("R7 no target write", {63'd0, result_we_o}, 64'd0);
        @(negedge clk); idle();
        #1 check("R7 R9 status after trap", {32'd0, fpscr_o}, 64'hE0104080);

        // R1: wrong extended opcode and missing strobe are ignored
        keep = fpscr_o;
        @(negedge clk);
        valid_i = 1; instr_i = mk(0, 5'd30, 1); ox_i = 1; fr_i = 1;
        #1 check("R1 bad xo no write", {62'd0, result_we_o, cr1_we_o}, 64'd0);
        @(negedge clk); idle();
        #1 check("R1 bad xo status", {32'd0, fpscr_o}, {32'd0, keep});
        @(negedge clk);
        valid_i = 0; instr_i = mk(1, 5'd31, 1); ox_i = 1; fr_i = 1;
        #1 check("R1 no strobe no write", {62'd0, result_we_o, cr1_we_o}, 64'd0);
        @(negedge clk); idle();
        #1 check("R1 no strobe status", {32'd0, fpscr_o}, {32'd0, keep});
        @(negedge clk);
        valid_i = 1; instr_i = {6'd31, 20'd0, 5'd31, 1'b0}; ox_i = 1;
        #1 check("R1 bad primary no write", {63'd0, result_we_o}, 64'd0);
        @(negedge clk); idle();
        #1 check("R1 bad primary status", {32'd0, fpscr_o}, {32'd0, keep});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule